// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous request port and an external asynchronous static RAM with a 17-bit address and an 8-bit data bus. A user issues one byte read or one byte write at a time over a valid/ready handshake. The controller then produces the chip-enable pair, output enable and write enable as a timed strobe sequence, drives the data bus only when the memory is certain to have released it, and returns read data with a one-cycle valid pulse.

Every phase length is a whole number of clock cycles. By default each count is derived from the clock period `CLK_PS` by rounding the memory's nanosecond limits up, with a floor of one cycle. The counts can also be overridden one by one. All memory-side pins come straight from flops, so the strobes cannot glitch. Output enable stays high for the whole write, so the memory never drives the bus while a write is in progress.

Top module: `async_sram_ctrl`

## Requirements
- R1: While and after reset, with no request yet accepted, the memory is deselected (`mem_ce_n_o`=1, `mem_ce_o`=0), `mem_oe_n_o`=1, `mem_we_n_o`=1, `mem_dq_oe_o`=0, `req_ready_o`=1 and `rsp_valid_o`=0.
- R2: A request is accepted only on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 from the cycle after acceptance until the sequence has returned to idle. With `req_valid_i` low the memory pins stay idle.
- R3: A read (`req_we_i`=0) keeps the memory selected with `mem_oe_n_o`=0 and `mem_we_n_o`=1 for exactly READ_CYC cycles. The bus is sampled at the end of the last of these cycles. `rsp_valid_o` is 1 for exactly one cycle, READ_CYC+1 cycles after the accepting edge, carrying that byte.
- R4: A write (`req_we_i`=1) has three phases. First come TURN_CYC selected cycles with write enable high and the bus released. Then write enable is low for PULSE_CYC = max(WE_PULSE_CYC, DATA_SETUP_CYC) cycles, with the write byte driven and stable throughout. Last comes one cycle with write enable high while the chip stays selected and address and data are still driven. The controller then reaches idle.
- R5: `mem_oe_n_o` is 1 in every cycle where `mem_we_n_o` is 0.
- R6: `mem_dq_oe_o` is 0 in any cycle where the memory is in its read condition (selected, `mem_oe_n_o`=0, `mem_we_n_o`=1), and in the cycle right after one.
- R7: `mem_ce_n_o` and `mem_ce_o` are complementary in every cycle.
- R8: `mem_addr_o` does not change between two consecutive cycles in which the chip is selected.
- R9: A read is followed by at least one deselected cycle before the chip is selected for the next access.
- R10: A read returns the byte of the most recent write to the same address.
- R11: Default counts are ceil(12 ns / period) for READ_CYC, ceil(10 ns / period) for WE_PULSE_CYC, ceil(7 ns / period) for DATA_SETUP_CYC and ceil(6 ns / period) for TURN_CYC, each at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and able to accept |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle read-data strobe |
| rsp_rdata_o | output | 8 | Read byte |
| mem_addr_o | output | 17 | Memory address pins |
| mem_ce_n_o | output | 1 | Active-low chip enable |
| mem_ce_o | output | 1 | Active-high chip enable |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_we_n_o | output | 1 | Active-low write enable |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Enable of the data bus drivers |
| mem_dq_i | input | 8 | Data received from the memory bus |

## Verification
The bench builds the controller with `CLK_PS`=5000, so the derived defaults give READ_CYC=3, WE_PULSE_CYC=2 and TURN_CYC=2. It sets DATA_SETUP_CYC=3 explicitly. Because the setup count exceeds the pulse count, the rule that the write-enable phase takes the larger of the two is exercised. The multi-cycle counts let the memory model return a corrupted byte until the read condition has lasted READ_CYC cycles, which exposes any early sample. The two-cycle turnaround makes the phase before the pulse observable as a separate length.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_END
  } state_e;

  // memory timing limits in ps
  localparam int RD_ACCESS_PS = 12000;
  localparam int WE_LOW_PS    = 10000;
  localparam int DATA_SU_PS   = 7000;
  localparam int BUS_OFF_PS   = 6000;

  function automatic int cyc_from_ps(int ps, int clk_ps);
    int n;
    n = (ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // expired counter must not wrap
  assert_timer_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W     = 2,
  parameter int READ_CYC  = 3,
  parameter int PULSE_CYC = 2,
  parameter int TURN_CYC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             we_i,
  input  logic             done_i,
  output state_e           state_q_o,
  output state_e           state_d_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);

  state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_IDLE: if (fire_i) begin
        load_o = 1'b1;
        if (we_i) begin
          state_d    = ST_WR_TURN;
          load_val_o = CNT_W'(TURN_CYC - 1);
        end else begin
          state_d    = ST_RD_ACCESS;
          load_val_o = CNT_W'(READ_CYC - 1);
        end
      end
      ST_RD_ACCESS:  if (done_i) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: state_d = ST_IDLE;
      ST_WR_TURN: if (done_i) begin
        state_d    = ST_WR_PULSE;
        load_o     = 1'b1;
        load_val_o = CNT_W'(PULSE_CYC - 1);
      end
      ST_WR_PULSE:   if (done_i) state_d = ST_WR_END;
      ST_WR_END:     state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

  // capture always returns to idle, so a read never runs into the next access
  assert_capture_to_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_CAPTURE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            state_q_i,
  input  state_e            state_d_i,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ce_n_o,
  output logic              ce_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  // strobes follow the next state, so pins and state change on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_o  <= 1'b1;
      ce_o    <= 1'b0;
      oe_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      unique case (state_d_i)
        ST_RD_ACCESS: begin
          ce_n_o <= 1'b0; ce_o <= 1'b1; oe_n_o <= 1'b0; we_n_o <= 1'b1; dq_oe_o <= 1'b0;
        end
        ST_WR_TURN: begin
          ce_n_o <= 1'b0; ce_o <= 1'b1; oe_n_o <= 1'b1; we_n_o <= 1'b1; dq_oe_o <= 1'b0;
        end
        ST_WR_PULSE: begin
          ce_n_o <= 1'b0; ce_o <= 1'b1; oe_n_o <= 1'b1; we_n_o <= 1'b0; dq_oe_o <= 1'b1;
        end
        ST_WR_END: begin
          ce_n_o <= 1'b0; ce_o <= 1'b1; oe_n_o <= 1'b1; we_n_o <= 1'b1; dq_oe_o <= 1'b1;
        end
        default: begin
          ce_n_o <= 1'b1; ce_o <= 1'b0; oe_n_o <= 1'b1; we_n_o <= 1'b1; dq_oe_o <= 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      dq_o   <= '0;
    end else if (accept_i) begin
      addr_o <= addr_i;
      dq_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= (state_d_i == ST_RD_CAPTURE);
      if (state_q_i == ST_RD_ACCESS && state_d_i == ST_RD_CAPTURE) rsp_rdata_o <= dq_i;
    end
  end

  assert_oe_off_in_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> oe_n_o);

  assert_no_drive_after_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_n_o || $past(!oe_n_o)) |-> !dq_oe_o);

  assert_addr_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_o && $past(!ce_n_o)) |-> $stable(addr_o));

  assert_rsp_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_enables_paired_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_o) |-> $fell(ce_n_o));

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 8,
  parameter int CLK_PS         = 5000,
  parameter int READ_CYC       = cyc_from_ps(RD_ACCESS_PS, CLK_PS),
  parameter int WE_PULSE_CYC   = cyc_from_ps(WE_LOW_PS, CLK_PS),
  parameter int DATA_SETUP_CYC = cyc_from_ps(DATA_SU_PS, CLK_PS),
  parameter int TURN_CYC       = cyc_from_ps(BUS_OFF_PS, CLK_PS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int PULSE_CYC = max2(WE_PULSE_CYC, DATA_SETUP_CYC);
  localparam int MAX_CYC   = max2(max2(READ_CYC, PULSE_CYC), TURN_CYC);
  localparam int CNT_W     = max2(1, $clog2(MAX_CYC + 1));

  state_e           state_q, state_d;
  logic             fire, load, done;
  logic [CNT_W-1:0] load_val;

  assign req_ready_o = (state_q == ST_IDLE);
  assign fire        = req_valid_i && req_ready_o;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  sram_seq_fsm #(
    .CNT_W     (CNT_W),
    .READ_CYC  (READ_CYC),
    .PULSE_CYC (PULSE_CYC),
    .TURN_CYC  (TURN_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .we_i       (req_we_i),
    .done_i     (done),
    .state_q_o  (state_q),
    .state_d_o  (state_d),
    .load_o     (load),
    .load_val_o (load_val)
  );

  sram_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_q_i   (state_q),
    .state_d_i   (state_d),
    .accept_i    (fire),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .dq_i        (mem_dq_i),
    .addr_o      (mem_addr_o),
    .ce_n_o      (mem_ce_n_o),
    .ce_o        (mem_ce_o),
    .oe_n_o      (mem_oe_n_o),
    .we_n_o      (mem_we_n_o),
    .dq_o        (mem_dq_o),
    .dq_oe_o     (mem_dq_oe_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  assert_ready_only_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_n_o && mem_we_n_o && !mem_dq_oe_o));

  assert_accept_leaves_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

endmodule

// File: tb/async_sram_ctrl_tb.sv
module async_sram_ctrl_tb;

  localparam int CLK_PS   = 5000;
  localparam int SETUP_IN = 3;
  // expected counts from the memory limits, independent of the RTL
  localparam int EXP_READ  = (12000 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_WEMIN = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_TURN  = (6000 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_PULSE = (EXP_WEMIN > SETUP_IN) ? EXP_WEMIN : SETUP_IN;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'h00;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;

  always #2500 clk = ~clk;

  async_sram_ctrl #(.CLK_PS(CLK_PS), .DATA_SETUP_CYC(SETUP_IN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_ce_n_o(mem_ce_n), .mem_ce_o(mem_ce),
    .mem_oe_n_o(mem_oe_n), .mem_we_n_o(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model contents and scoreboard
  logic [7:0] mem_model [bit [16:0]];
  logic [7:0] ref_mem   [bit [16:0]];

  function automatic logic [7:0] model_rd(logic [16:0] a);
    if (mem_model.exists(a)) return mem_model[a];
    return 8'h00;
  endfunction

  function automatic logic [7:0] ref_rd(logic [16:0] a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return 8'h00;
  endfunction

  // pin-level memory model and protocol monitor, evaluated mid-cycle
  bit          prev_rd = 0, prev_sel = 0, prev_wr = 0;
  int          rd_cnt = 0, wr_cnt = 0, st_cnt = 0, pre_cnt = 0;
  logic [16:0] prev_addr = '0;
  logic [7:0]  prev_wd = '0;

  always @(negedge clk) begin
    bit sel, rd, wr;
    if (rst_n && model_on) begin
      sel = !mem_ce_n && mem_ce;
      rd  = sel && !mem_oe_n && mem_we_n;
      wr  = sel && !mem_we_n;
      chk(mem_ce_n != mem_ce, "R7", "enable pair", {mem_ce_n, mem_ce}, 2'b10);
      chk(!(!mem_we_n && !mem_oe_n), "R5", "oe during we", mem_oe_n, 1);
      chk(!(mem_dq_oe && (rd || prev_rd)), "R6", "bus drive near read", mem_dq_oe, 0);
      if (sel && prev_sel) chk(mem_addr == prev_addr, "R8", "addr stable", mem_addr, prev_addr);
      chk(!(sel && prev_rd && !rd), "R9", "gap after read", sel, 0);
      // read phase length
      if (rd) rd_cnt++;
      else if (prev_rd) begin
        chk(rd_cnt == EXP_READ, "R3", "read cycles", rd_cnt, EXP_READ);
        rd_cnt = 0;
      end
      // turnaround phase before the write pulse
      if (sel && mem_we_n && mem_oe_n && !mem_dq_oe) pre_cnt++;
      else if (!sel) pre_cnt = 0;
      if (wr) begin
        if (!prev_wr) begin
          chk(pre_cnt == EXP_TURN, "R11", "turn cycles", pre_cnt, EXP_TURN);
          pre_cnt = 0;
        end
        chk(mem_dq_oe == 1'b1, "R4", "data driven in pulse", mem_dq_oe, 1);
        if (prev_wr && mem_dq_o == prev_wd) st_cnt++;
        else st_cnt = 1;
        wr_cnt++;
        prev_wd = mem_dq_o;
      end else if (prev_wr) begin
        chk(wr_cnt == EXP_PULSE, "R4", "we low cycles", wr_cnt, EXP_PULSE);
        chk(st_cnt >= SETUP_IN, "R4", "data setup cycles", st_cnt, SETUP_IN);
        chk(sel && mem_dq_oe && mem_dq_o == prev_wd && mem_addr == prev_addr,
            "R4", "hold after we rise", mem_dq_o, prev_wd);
        mem_model[prev_addr] = prev_wd;
        wr_cnt = 0;
      end
      // the byte is valid only once the read condition has lasted long enough
      mem_dq_i <= (rd && rd_cnt >= EXP_READ) ? model_rd(mem_addr) : ~model_rd(mem_addr);
      prev_rd   = rd;
      prev_sel  = sel;
      prev_wr   = wr;
      prev_addr = mem_addr;
    end
  end

  task automatic chk_idle(input string req);
    chk(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe, req, "idle pins",
        {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    chk(req_ready && !rsp_valid, req, "ready/valid idle", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int n;
    wait_ready();
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    ref_mem[a] = d;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~d;
    chk(!req_ready, "R2", "busy after write accept", req_ready, 0);
    n = 1;
    while (!req_ready) begin
      @(negedge clk);
      n++;
    end
    chk(n == EXP_TURN + EXP_PULSE + 2, "R4", "write sequence length", n, EXP_TURN + EXP_PULSE + 2);
  endtask

  task automatic do_read(input logic [16:0] a);
    logic [7:0] exp;
    wait_ready();
    exp = ref_rd(a);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a;
    chk(!req_ready, "R2", "busy after read accept", req_ready, 0);
    for (int i = 1; i <= EXP_READ; i++) begin
      if (i > 1) @(negedge clk);
      chk(!rsp_valid, "R3", "early rsp_valid", rsp_valid, 0);
    end
    @(negedge clk);
    chk(rsp_valid, "R3", "rsp_valid", rsp_valid, 1);
    chk(rsp_rdata == exp, "R10", "read data", rsp_rdata, exp);
    @(negedge clk);
    chk(!rsp_valid, "R3", "rsp_valid width", rsp_valid, 0);
    chk(req_ready, "R2", "ready after read", req_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    // R2: no request, nothing moves
    repeat (4) @(negedge clk);
    chk_idle("R2");
    // R11 default counts seen through lengths, R10 basic round trip
    do_write(17'h00000, 8'h3C);
    do_read(17'h00000);
    do_write(17'h1FFFF, 8'hC3);
    do_read(17'h1FFFF);
    do_read(17'h00000);
    // R10: last write wins
    do_write(17'h00042, 8'h11);
    do_write(17'h00042, 8'hEE);
    do_read(17'h00042);
    // R9/R6: write immediately after a read
    do_read(17'h1FFFF);
    do_write(17'h1FFFF, 8'h5A);
    do_read(17'h1FFFF);
    // never-written address reads the model default
    do_read(17'h0ABCD);
    for (int k = 0; k < 300; k++) begin
      logic [16:0] a;
      a = (($urandom % 2) != 0 ? 17'h1FFC0 : 17'h00000) | 17'($urandom % 16);
      if (($urandom % 2) != 0) do_write(a, 8'($urandom));
      else                      do_read(a);
      if (($urandom % 4) == 0) repeat ($urandom % 3) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk_idle("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule